// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status flags of an asynchronous serial port: transmit buffer empty, receive buffer full, overrun, framing error, parity error, transmit finished, the multiprocessor bit of the last received character, and the multiprocessor bit to be sent. Single-cycle event pulses from the transmit and receive datapaths set the flags. The receiver reports each finished character together with its data, parity bit and sampled stop bit. Parity checking against an even or odd mode input is done here.

Software sees all eight flags as one status byte. The error and buffer flags can be cleared in two ways. Software can write 0 to a flag that an earlier status read returned as 1. Reading the receive buffer or writing the transmit buffer also clears the matching flags. Writing 1 to a status bit never sets a flag. No data stream passes through this block, so every pin is a plain control or status level or pulse, and there is no valid/ready handshake.

Top module: `serial_status_reg`

## Requirements
- R1: After reset the status byte is 8'h84: transmit-empty (bit 7) and transmit-end (bit 2) are 1 and every other bit is 0.
- R2: A status write with 0 in bit 7, 6, 5, 4 or 3 clears that flag only if a status read since the flag last became 0 returned it as 1. The clear disarms that flag's read marker. A 0 written to an unarmed flag has no effect.
- R3: Writing 1 to bits 7..3 leaves those flags unchanged. Bit 0 (transmit multiprocessor bit) takes the written value on every status write.
- R4: A finished character with stop bit 1 and no parity error sets receive-full (bit 6). A receive-buffer read clears it.
- R5: A character that finishes while receive-full is 1 sets overrun (bit 5). Receive-full stays 1.
- R6: A finished character whose stop bit is 0 sets framing error (bit 4) and does not set receive-full.
- R7: When parity checking is enabled, parity error (bit 3) sets if the XOR of the data bits and the parity bit differs from the mode input (0 even, 1 odd). In that case receive-full is not set. When checking is disabled, bit 3 never sets.
- R8: Transmit-empty sets on a buffer-to-shift-register transfer or while transmit-enable is 0. A transmit-buffer write clears it.
- R9: Transmit-end (bit 2, read-only) sets while transmit-enable is 0, or when the last bit goes out while transmit-empty is 1. A last-bit pulse with transmit-empty 0 has no effect. Transmit-end clears on a transmit-buffer write or when a software clear of transmit-empty takes effect.
- R10: Bit 1 captures the multiprocessor bit of every finished character and ignores status writes.
- R11: A hardware set and a clear of the same flag in the same cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable level |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity mode: 0 even, 1 odd |
| sts_rd | input | 1 | Status byte read strobe |
| sts_wr | input | 1 | Status byte write strobe |
| sts_wdata | input | 8 | Status write data |
| rxbuf_rd | input | 1 | Receive buffer read strobe |
| txbuf_wr | input | 1 | Transmit buffer write strobe |
| tx_load | input | 1 | Transmit buffer moved to shift register |
| tx_last | input | 1 | Last bit of a character sent |
| rx_done | input | 1 | Character reception finished |
| rx_data | input | DATA_W | Received data bits, valid with rx_done |
| rx_par_bit | input | 1 | Received parity bit, valid with rx_done |
| rx_stop_bit | input | 1 | Sampled stop bit, valid with rx_done |
| rx_mpb | input | 1 | Received multiprocessor bit, valid with rx_done |
| sts_q | output | 8 | Status byte |

## Verification
The assertions assume that every strobe and event input is a clean single-cycle level sampled at the clock edge. They also assume that the receive fields carry a defined value in any cycle where rx_done is high. The bench drives all inputs on the falling edge, keeps the receive fields at defined values at all times, and releases each pulse after one cycle. It deliberately lets hardware events coincide with status writes and buffer accesses, so the set-priority and per-flag arming rules are exercised.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int STS_W    = 8;
  localparam int B_TDRE   = 7;
  localparam int B_RDRF   = 6;
  localparam int B_OVR    = 5;
  localparam int B_FRM    = 4;
  localparam int B_PAR    = 3;
  localparam int B_TEND   = 2;
  localparam int B_MPRX   = 1;
  localparam int B_MPTX   = 0;
  localparam int CLR_LO   = B_PAR;
  localparam int CLR_HI   = B_TDRE;
  localparam logic [STS_W-1:0] STS_RESET = 8'h84;
endpackage

// File: rtl/ssr_flag_cell.sv
module ssr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_rd,
  input  logic sw_wr,
  input  logic sw_wbit,
  output logic q,
  output logic sw_clr_done
);
  logic armed;
  logic sw_clr;
  logic q_nxt;

  always_comb begin
    sw_clr = sw_wr & ~sw_wbit & armed;
    if (hw_set)                q_nxt = 1'b1;
    else if (hw_clr || sw_clr) q_nxt = 1'b0;
    else                       q_nxt = q;
  end

  assign sw_clr_done = sw_clr & ~hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= RST_VAL;
      armed <= 1'b0;
    end else begin
      q <= q_nxt;
      if (!q_nxt)          armed <= 1'b0;
      else if (sw_rd && q) armed <= 1'b1;
    end
  end

  // R11: a set always wins over any clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);
  // R2: an unarmed flag ignores a software zero
  p_unarmed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !armed && !hw_clr) |=> q);
  // R3: writing one never clears
  p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !hw_clr && sw_wr && sw_wbit) |=> q);
endmodule

// File: rtl/ssr_rx_eval.sv
module ssr_rx_eval #(
  parameter int DATA_W = 8
) (
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_bit,
  input  logic              rx_stop_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rdrf_q,
  output logic              rdrf_set,
  output logic              oer_set,
  output logic              fer_set,
  output logic              per_set
);
  logic ones_odd;
  logic par_bad;

  always_comb begin
    ones_odd = ^{rx_data, rx_par_bit};
    par_bad  = par_en & (ones_odd != par_odd);
    fer_set  = rx_done & ~rx_stop_bit;
    per_set  = rx_done & par_bad;
    oer_set  = rx_done & rdrf_q;
    rdrf_set = rx_done & rx_stop_bit & ~par_bad;
  end

  // R4: a full-buffer set never accompanies a receive error
  always_comb begin
    p_good_excl_r4: assert (!(rdrf_set && (fer_set || per_set)));
  end
endmodule

// File: rtl/ssr_tx_track.sv
module ssr_tx_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last,
  input  logic txbuf_wr,
  input  logic tdre_q,
  input  logic tdre_sw_clr,
  output logic tdre_set,
  output logic tend_q
);
  logic tend_set;
  logic tend_clr;

  always_comb begin
    tdre_set = ~tx_en | tx_load;
    tend_set = ~tx_en | (tx_last & tdre_q);
    tend_clr = txbuf_wr | tdre_sw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tend_q <= 1'b1;
    else if (tend_set) tend_q <= 1'b1;
    else if (tend_clr) tend_q <= 1'b0;
  end

  // R9: transmitter disabled forces end-of-transmission
  p_txen_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tend_q);
  // R9: last bit with empty buffer marks completion
  p_last_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && tdre_q) |=> tend_q);
  // R9: buffer write clears completion when nothing sets it
  p_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && tx_en && !(tx_last && tdre_q)) |=> !tend_q);
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic [STS_W-1:0]  sts_wdata,
  input  logic              rxbuf_rd,
  input  logic              txbuf_wr,
  input  logic              tx_load,
  input  logic              tx_last,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_bit,
  input  logic              rx_stop_bit,
  input  logic              rx_mpb,
  output logic [STS_W-1:0]  sts_q
);
  logic [CLR_HI:CLR_LO] hw_set;
  logic [CLR_HI:CLR_LO] hw_clr;
  logic [CLR_HI:CLR_LO] flag_q;
  logic [CLR_HI:CLR_LO] clr_done;
  logic rdrf_set, oer_set, fer_set, per_set, tdre_set;
  logic tend_q, mprx_q, mptx_q;
  logic unused_bits;

  assign unused_bits = ^{sts_wdata[B_TEND:B_MPRX], clr_done[CLR_HI-1:CLR_LO]};

  ssr_rx_eval #(.DATA_W(DATA_W)) rx_eval_i (
    .rx_done(rx_done), .rx_data(rx_data), .rx_par_bit(rx_par_bit),
    .rx_stop_bit(rx_stop_bit), .par_en(par_en), .par_odd(par_odd),
    .rdrf_q(flag_q[B_RDRF]), .rdrf_set(rdrf_set), .oer_set(oer_set),
    .fer_set(fer_set), .per_set(per_set)
  );

  ssr_tx_track tx_track_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_load(tx_load),
    .tx_last(tx_last), .txbuf_wr(txbuf_wr), .tdre_q(flag_q[B_TDRE]),
    .tdre_sw_clr(clr_done[B_TDRE]), .tdre_set(tdre_set), .tend_q(tend_q)
  );

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[B_TDRE] = tdre_set;
    hw_set[B_RDRF] = rdrf_set;
    hw_set[B_OVR]  = oer_set;
    hw_set[B_FRM]  = fer_set;
    hw_set[B_PAR]  = per_set;
    hw_clr[B_TDRE] = txbuf_wr;
    hw_clr[B_RDRF] = rxbuf_rd;
  end

  for (genvar i = CLR_LO; i <= CLR_HI; i++) begin : g_flag
    ssr_flag_cell #(.RST_VAL(STS_RESET[i])) cell_i (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]), .hw_clr(hw_clr[i]),
      .sw_rd(sts_rd), .sw_wr(sts_wr), .sw_wbit(sts_wdata[i]),
      .q(flag_q[i]), .sw_clr_done(clr_done[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mprx_q <= STS_RESET[B_MPRX];
      mptx_q <= STS_RESET[B_MPTX];
    end else begin
      if (rx_done) mprx_q <= rx_mpb;
      if (sts_wr)  mptx_q <= sts_wdata[B_MPTX];
    end
  end

  assign sts_q = {flag_q, tend_q, mprx_q, mptx_q};

  // R5: completion while full flags an overrun and keeps the full flag
  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && sts_q[B_RDRF]) |=> (sts_q[B_OVR] && sts_q[B_RDRF]));
  // R6: bad stop bit flags a framing error
  p_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_stop_bit) |=> sts_q[B_FRM]);
  // R10: received multiprocessor bit follows each character
  p_mprx_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (sts_q[B_MPRX] == $past(rx_mpb)));
  // R10: without a character the received bit holds
  p_mprx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(sts_q[B_MPRX]));
  // R3: transmit multiprocessor bit follows writes
  p_mptx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> (sts_q[B_MPTX] == $past(sts_wdata[B_MPTX])));
  // R8: disabled transmitter or a load marks the buffer empty
  p_tdre_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || tx_load) |=> sts_q[B_TDRE]);
endmodule

// File: tb/serial_status_reg_tb_top.sv
`timescale 1ns/1ps
module serial_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1, par_en = 1'b1, par_odd = 1'b0;
  logic sts_rd = 1'b0, sts_wr = 1'b0;
  logic [7:0] sts_wdata = 8'h00;
  logic rxbuf_rd = 1'b0, txbuf_wr = 1'b0, tx_load = 1'b0, tx_last = 1'b0;
  logic rx_done = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_par_bit = 1'b0, rx_stop_bit = 1'b1, rx_mpb = 1'b0;
  logic [7:0] sts_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_en(par_en), .par_odd(par_odd),
    .sts_rd(sts_rd), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .rxbuf_rd(rxbuf_rd), .txbuf_wr(txbuf_wr), .tx_load(tx_load),
    .tx_last(tx_last), .rx_done(rx_done), .rx_data(rx_data),
    .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit), .rx_mpb(rx_mpb),
    .sts_q(sts_q)
  );

  // {ten,rd,wr,wd[8],drd,twr,ld,last,rxd,stop,pbit,mpb,dat[8],exp[8],req[8]}
  localparam int NV = 30;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h84, 8'd1},  // R1 idle
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd8},  // R8 buffer write
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h80, 8'd8},  // R8 load
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h84, 8'd9},  // R9 last bit
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd9},  // R9 write clears
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd9},  // R9 last, not empty
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b1, 8'h03, 8'h42, 8'd4},  // R4 R10 good char
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'h03, 8'h60, 8'd5},  // R5 overrun
    {1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h60, 8'd2},  // R2 unarmed
    {1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h60, 8'd2},  // R2 read arms
    {1'b1,1'b0,1'b1,8'hFF, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h61, 8'd3},  // R3 R10 write ones
    {1'b1,1'b0,1'b1,8'hDF, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h41, 8'd2},  // R2 clear overrun
    {1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd2},  // R2 clear full
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 8'h03, 8'h10, 8'd6},  // R6 framing
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'h01, 8'h18, 8'd7},  // R7 parity
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'h03, 8'h58, 8'd4},  // R4 good char
    {1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h18, 8'd4},  // R4 buffer read
    {1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h18, 8'd2},  // R2 read arms
    {1'b1,1'b0,1'b1,8'hF7, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h11, 8'd2},  // R2 clear parity
    {1'b1,1'b0,1'b1,8'hE1, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h01, 8'd2},  // R2 clear framing
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h81, 8'd8},  // R8 load
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h85, 8'd9},  // R9 last bit
    {1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h85, 8'd2},  // R2 read arms
    {1'b1,1'b0,1'b1,8'h7E, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd9},  // R9 sw clear empty
    {1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h80, 8'd8},  // R8 load
    {1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h80, 8'd2},  // R2 read arms
    {1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h80, 8'd11}, // R11 load vs clear
    {1'b1,1'b0,1'b1,8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd2},  // R2 still armed
    {1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 8'h03, 8'h40, 8'd11}, // R11 char vs read
    {1'b1,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h00, 8'd4}   // R4 buffer read
  };

  task automatic check(input logic [7:0] exp, input int req, input string what);
    n_chk++;
    if (sts_q !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, sts_q, exp);
    end
  endtask

  task automatic step(input logic [42:0] v, input string what);
    @(negedge clk);
    tx_en = v[42]; sts_rd = v[41]; sts_wr = v[40]; sts_wdata = v[39:32];
    rxbuf_rd = v[31]; txbuf_wr = v[30]; tx_load = v[29]; tx_last = v[28];
    rx_done = v[27]; rx_stop_bit = v[26]; rx_par_bit = v[25]; rx_mpb = v[24];
    rx_data = v[23:16];
    @(negedge clk);
    check(v[15:8], int'(v[7:0]), what);
    sts_rd = 1'b0; sts_wr = 1'b0; rxbuf_rd = 1'b0; txbuf_wr = 1'b0;
    tx_load = 1'b0; tx_last = 1'b0; rx_done = 1'b0; rx_stop_bit = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(8'h84, 1, "reset value");  // R1
    for (int i = 0; i < NV; i++) step(VEC[i], $sformatf("table step %0d", i));

    // R1: reset in the middle of activity
    step({1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'd8}, "pre-reset write");
    do_reset();
    check(8'h84, 1, "reset after activity");

    // R7: odd mode, one data one and parity 0 is good
    par_odd = 1'b1;
    step({1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h01,8'hC4,8'd7}, "odd parity ok");
    // R7 R5: odd mode, two ones and parity 0 is bad, full gives overrun
    step({1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h03,8'hEC,8'd7}, "odd parity bad");

    // R7: checking disabled
    do_reset();
    par_odd = 1'b0;
    par_en = 1'b0;
    step({1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h01,8'hC6,8'd7}, "parity disabled");
    par_en = 1'b1;

    // R8 R9: transmitter disable sets both transmit flags
    step({1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h42,8'd8}, "write empties");
    step({1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hC6,8'd9}, "disable sets");
    // R11: buffer write while disabled loses to the set
    step({1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hC6,8'd11}, "disabled write");
    tx_en = 1'b1;

    finish_run();
  end
endmodule